// File: doc/BRIEF.md
# Bidirectional I/O Port Bank with Complementary Buzzer Output

This block holds three general-purpose I/O ports on a small byte-wide register bus: port A and port B with eight lines each, and port C with three lines, so nineteen pad lines in all. Each port has two registers. The data latch holds the value the pins drive. The direction register chooses, one bit per line, between input and push-pull output. The block drives an output value and an output enable for every pad. It passes pad inputs through a synchronizer so they can be read.

A data read is built per line. An input line returns its synchronized pad level. An output line returns its latch bit, so read-modify-write bit operations keep the values of output lines unchanged. Any change on a port A input line raises a one-cycle wake request. A tone signal from an outside timer can be routed onto the two lowest port B lines as a complementary pair. That pair is gated only by the lowest port B data bit.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, every direction bit is 1. Reads of 13h, 15h and 17h return FFh, FFh and 07h, and pad_oe is all zero. Every data latch bit is 1, so a line switched to output afterwards drives 1.
- R2: The data latches of ports A, B and C are at bus addresses 12h, 14h and 16h. Their direction registers are at 13h, 15h and 17h. A write to any other address changes no register, and a read of any other address returns 0.
- R3: A direction bit of 0 makes the line an output: pad_oe is 1 and pad_out is its latch bit. A direction bit of 1 makes the line an input with pad_oe at 0.
- R4: A data read returns, for each bit whose direction bit is 1, the pad level after a two-flop synchronizer. For each bit whose direction bit is 0, it returns the latch bit. The value is valid in the same cycle as bus_rd.
- R5: A latch holds its value until its own data address is written. Direction writes and pad changes leave pad_out of non-buzzer lines unchanged.
- R6: Port C has only bits 2..0. Bits 7..3 read as 0 at 16h and 17h, and writes to those bits have no effect.
- R7: wake_req is high for exactly one cycle after a synchronized port A line in input mode changes level. Lines in output mode never raise it.
- R8: While buzz_en is 1, PB0 (pad line 8) in output mode drives tone_in AND the PB0 latch bit. PB1 (pad line 9) in output mode drives the inverse of tone_in AND the PB0 latch bit. A buzzer line in input mode keeps pad_oe at 0.
- R9: While buzz_en is 1, the PB1 latch bit has no effect on either buzzer pin. A PB0 latch bit of 0 makes both pins drive 0.
- R10: bus_rdata is 0 in any cycle where bus_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rd |
| pad_in | input | 19 | Pad levels: A in 7..0, B in 15..8, C in 18..16 |
| pad_out | output | 19 | Pad drive values |
| pad_oe | output | 19 | Pad output enables |
| tone_in | input | 1 | Buzzer tone from an outside timer |
| buzz_en | input | 1 | Routes the tone onto PB0/PB1 |
| wake_req | output | 1 | One-cycle wake request from a port A input change |

## Verification
The hardest case to reach is a data read that mixes sources within one byte: some bits come from the synchronized pads and others from the latch. The bench loads a latch pattern and a pad pattern that differ, then sets a direction mask that splits the byte. Only a correct per-bit mix gives the expected value. The wake pulse depends on two flops of delay, so the bench changes one pad at a falling edge and samples wake_req at precisely the second and third falling edges after it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_PORTS = 3;

  function automatic int port_width(input int p);
    return (p == 2) ? 3 : 8;
  endfunction

  function automatic int port_base(input int p);
    int acc;
    acc = 0;
    for (int i = 0; i < p; i++) acc += port_width(i);
    return acc;
  endfunction

  localparam int TOTAL_LINES = port_base(NUM_PORTS);
  localparam int BUZ_LINE_P = port_base(1);
  localparam int BUZ_LINE_N = port_base(1) + 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int              W         = 8,
  parameter int              BUS_W     = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      wr_bits,
  input  logic [W-1:0]      pad_sync,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [BUS_W-1:0]  rd_val
);
  logic          hit_data;
  logic          hit_ctrl;
  logic [W-1:0]  mixed;

  assign hit_data = (bus_addr == DATA_ADDR);
  assign hit_ctrl = (bus_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      dir_q   <= '1;
    end else if (bus_wr) begin
      if (hit_data) latch_q <= wr_bits;
      if (hit_ctrl) dir_q   <= wr_bits;
    end
  end

  // input lines show the synchronized pad, output lines show the latch
  assign mixed = (dir_q & pad_sync) | (~dir_q & latch_q);

  always_comb begin
    rd_val = '0;
    if (hit_data)      rd_val[W-1:0] = mixed;
    else if (hit_ctrl) rd_val[W-1:0] = dir_q;
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int LINES  = 19,
  parameter int BUZ_P  = 8,
  parameter int BUZ_N  = 9
) (
  input  logic [LINES-1:0] latch_all,
  input  logic [LINES-1:0] dir_all,
  input  logic             tone_in,
  input  logic             buzz_en,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe
);
  logic gate;

  assign gate = latch_all[BUZ_P];

  always_comb begin
    pad_oe  = ~dir_all;
    pad_out = latch_all;
    if (buzz_en) begin
      if (!dir_all[BUZ_P]) pad_out[BUZ_P] = gate & tone_in;
      if (!dir_all[BUZ_N]) pad_out[BUZ_N] = gate & ~tone_in;
    end
  end
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int W      = 8,
  parameter int SETTLE = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] dir_in,
  output logic         wake
);
  logic [W-1:0]      prev_q;
  logic [SETTLE-1:0] armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      armed_q <= '0;
    end else begin
      prev_q  <= sync_in;
      armed_q <= {armed_q[SETTLE-2:0], 1'b1};
    end
  end

  // the armed chain hides the synchronizer fill right after reset
  assign wake = armed_q[SETTLE-1] & (|((sync_in ^ prev_q) & dir_in));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              BUS_W       = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic [BUS_W-1:0]       bus_rdata,
  input  logic [TOTAL_LINES-1:0] pad_in,
  output logic [TOTAL_LINES-1:0] pad_out,
  output logic [TOTAL_LINES-1:0] pad_oe,
  input  logic                   tone_in,
  input  logic                   buzz_en,
  output logic                   wake_req
);
  localparam int LINES = TOTAL_LINES;
  localparam int WAKE_W = port_width(0);

  logic [LINES-1:0] pad_sync;
  logic [LINES-1:0] latch_all;
  logic [LINES-1:0] dir_all;
  logic [BUS_W-1:0] port_rd [NUM_PORTS];
  logic [BUS_W-1:0] rd_acc;

  gpio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pad_in),
    .d_out (pad_sync)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int PW = port_width(p);
      localparam int PB = port_base(p);
      localparam logic [ADDR_W-1:0] DA = BASE_ADDR + ADDR_W'(2 * p);
      localparam logic [ADDR_W-1:0] CA = BASE_ADDR + ADDR_W'(2 * p + 1);
      gpio_port #(
        .W(PW), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
        .DATA_ADDR(DA), .CTRL_ADDR(CA)
      ) u_port (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .wr_bits  (bus_wdata[PW-1:0]),
        .pad_sync (pad_sync[PB +: PW]),
        .latch_q  (latch_all[PB +: PW]),
        .dir_q    (dir_all[PB +: PW]),
        .rd_val   (port_rd[p])
      );
    end
  endgenerate

  always_comb begin
    rd_acc = '0;
    for (int i = 0; i < NUM_PORTS; i++) rd_acc = rd_acc | port_rd[i];
  end

  assign bus_rdata = bus_rd ? rd_acc : '0;

  gpio_pinmux #(.LINES(LINES), .BUZ_P(BUZ_LINE_P), .BUZ_N(BUZ_LINE_N)) u_mux (
    .latch_all (latch_all),
    .dir_all   (dir_all),
    .tone_in   (tone_in),
    .buzz_en   (buzz_en),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  gpio_wake #(.W(WAKE_W), .SETTLE(SYNC_STAGES + 1)) u_wake (
    .clk     (clk),
    .rst     (rst),
    .sync_in (pad_sync[WAKE_W-1:0]),
    .dir_in  (dir_all[WAKE_W-1:0]),
    .wake    (wake_req)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic [18:0] pad_out,
  input logic [18:0] pad_oe,
  input logic        tone_in,
  input logic        buzz_en,
  input logic        wake_req
);
  assert_dir_to_oe_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 8'h13) |=> (pad_oe[7:0] == ~$past(bus_wdata)));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 8'h12) |=> $stable(pad_out[7:0]));

  assert_portc_data_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 8'h16) |-> (bus_rdata[7:3] == 5'd0));

  assert_portc_ctrl_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 8'h17) |-> (bus_rdata[7:3] == 5'd0));

  assert_wake_input_R7: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (pad_oe[7:0] != 8'hFF));

  assert_buzz_p_R8: assert property (@(posedge clk) disable iff (rst)
    (buzz_en && pad_oe[8] && pad_out[8]) |-> tone_in);

  assert_buzz_n_R8: assert property (@(posedge clk) disable iff (rst)
    (buzz_en && pad_oe[9] && pad_out[9]) |-> !tone_in);

  assert_buzz_excl_R9: assert property (@(posedge clk) disable iff (rst)
    (buzz_en && pad_oe[8] && pad_oe[9]) |-> !(pad_out[8] && pad_out[9]));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .tone_in   (tone_in),
  .buzz_en   (buzz_en),
  .wake_req  (wake_req)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [18:0] pad_in;
  logic [18:0] pad_out;
  logic [18:0] pad_oe;
  logic        tone_in;
  logic        buzz_en;
  logic        wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .tone_in(tone_in), .buzz_en(buzz_en), .wake_req(wake_req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_read(8'h13, v); check("R1 dir A", v, 8'hFF);
    bus_read(8'h15, v); check("R1 dir B", v, 8'hFF);
    bus_read(8'h17, v); check("R1 dir C", v, 8'h07);
    check("R1 oe", pad_oe, 19'h0);
    bus_write(8'h13, 8'h00);
    #1 check("R1 latch A ones", pad_out[7:0], 8'hFF);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bus_write(8'h12, 8'hA5);
    bus_read(8'h12, v); check("R2 data A", v, 8'hA5);
    bus_write(8'h15, 8'h00);
    bus_write(8'h14, 8'h3C);
    bus_read(8'h14, v); check("R2 data B", v, 8'h3C);
    bus_write(8'h20, 8'h55);
    bus_read(8'h20, v); check("R2 unmapped read", v, 8'h00);
    bus_read(8'h12, v); check("R2 unmapped write A", v, 8'hA5);
    bus_read(8'h14, v); check("R2 unmapped write B", v, 8'h3C);
  endtask

  task automatic t_outputs();
    bus_write(8'h13, 8'h0F);
    #1;
    check("R3 oe A", pad_oe[7:0], 8'hF0);
    check("R3 out A", pad_out[7:0], 8'hA5);
  endtask

  task automatic t_readmix();
    logic [7:0] v;
    @(negedge clk); pad_in[7:0] = 8'h3C;
    settle(3);
    bus_read(8'h12, v); check("R4 mixed read", v, 8'hAC);
    @(negedge clk); pad_in[7:0] = 8'hC3;
    #1;
    bus_read(8'h12, v); check("R4 sync delay", v, 8'hAC);
    settle(2);
    bus_read(8'h12, v); check("R4 after sync", v, 8'hA3);
  endtask

  task automatic t_hold();
    bus_write(8'h13, 8'hFF);
    bus_write(8'h13, 8'h00);
    @(negedge clk); pad_in[7:0] = 8'hFF;
    settle(3);
    check("R5 hold", pad_out[7:0], 8'hA5);
  endtask

  task automatic t_portc();
    logic [7:0] v;
    bus_write(8'h16, 8'hFF);
    bus_write(8'h17, 8'h00);
    bus_read(8'h16, v); check("R6 data C", v, 8'h07);
    check("R6 out C", pad_out[18:16], 3'b111);
    bus_write(8'h17, 8'hF8);
    bus_read(8'h17, v); check("R6 dir C", v, 8'h00);
    bus_write(8'h16, 8'hFA);
    bus_read(8'h16, v); check("R6 data C write", v, 8'h02);
    bus_write(8'h17, 8'h07);
  endtask

  task automatic t_wake();
    bus_write(8'h13, 8'hFF);
    settle(4);
    check("R7 quiet", wake_req, 1'b0);
    @(negedge clk); pad_in[3] = ~pad_in[3];
    @(negedge clk);
    check("R7 before sync", wake_req, 1'b0);
    @(negedge clk);
    check("R7 pulse", wake_req, 1'b1);
    @(negedge clk);
    check("R7 pulse ends", wake_req, 1'b0);
    bus_write(8'h13, 8'h00);
    @(negedge clk); pad_in[5] = ~pad_in[5];
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 output line silent", wake_req, 1'b0);
    end
  endtask

  task automatic t_buzzer();
    bus_write(8'h15, 8'hFC);
    bus_write(8'h14, 8'h01);
    @(negedge clk); buzz_en = 1'b1; tone_in = 1'b1;
    #1 check("R8 tone high", pad_out[9:8], 2'b01);
    @(negedge clk); tone_in = 1'b0;
    #1 check("R8 tone low R9 pb1 latch ignored", pad_out[9:8], 2'b10);
    bus_write(8'h14, 8'h02);
    #1 check("R9 gate off tone low", pad_out[9:8], 2'b00);
    @(negedge clk); tone_in = 1'b1;
    #1 check("R9 gate off tone high", pad_out[9:8], 2'b00);
    @(negedge clk); buzz_en = 1'b0;
    #1 check("R8 buzz off latch", pad_out[9:8], 2'b10);
    bus_write(8'h14, 8'h01);
    bus_write(8'h15, 8'hFD);
    @(negedge clk); buzz_en = 1'b1; tone_in = 1'b0;
    #1;
    check("R8 pb0 input oe", pad_oe[9:8], 2'b10);
    check("R8 pb1 still buzzes", pad_out[9], 1'b1);
    @(negedge clk); buzz_en = 1'b0;
  endtask

  task automatic t_idle();
    @(negedge clk);
    bus_addr = 8'h12; bus_rd = 1'b0;
    #1 check("R10 idle rdata", bus_rdata, 8'h00);
  endtask

  initial begin
    rst = 1'b1; bus_addr = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 8'h00; pad_in = 19'h0; tone_in = 1'b0; buzz_en = 1'b0;
    settle(4);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_outputs();
    t_readmix();
    t_hold();
    t_portc();
    t_wake();
    t_buzzer();
    t_idle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule